// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight status flags of a small processor core in one 8-bit register. The flags are carry, zero, negative, overflow, sign, half-carry, transfer and global interrupt enable. On every clock edge each flag takes one of four actions, chosen by its own 2-bit control field:

- keep its value;
- load from the ALU result flags;
- clear;
- set.

The sign flag is the one exception to a plain load. It is never taken from the ALU. It is recomputed as the exclusive OR of the new negative and overflow flags.

Two bit-transfer paths serve the bit-store and bit-load operations:

- **Bit store.** Copies one selected bit of a register operand into the transfer flag.
- **Bit load.** Returns an operand with one selected bit replaced by the transfer flag. This path is combinational.

A single-flag write port forces any one flag to 1 or to 0, chosen by a 3-bit index. It has the highest priority of all update sources.

The decoder drives the control fields, the bit-transfer strobes and the single-flag strobes. The ALU supplies the raw result flags. The register value and the derived signed-test flag feed conditional branches and interrupt logic.

Top module: `psr_flags`

## Requirements
- R1: While rst_ni is low, psr_o reads 0x00 and sign_o reads 0, so interrupts start disabled.
- R2: The bit positions in psr_o are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.
  - The control field for bit b is flag_ctl_i[2b+1:2b]. Its codes are 00 keep, 01 load from alu_flags_i[b], 10 clear and 11 set.
  - The action takes effect on the next rising clock edge.
- R3: When the S field is 01, S becomes the XOR of the N and V values being written in the same cycle. alu_flags_i[4] has no effect.
- R4: sign_o always equals psr_o[2] XOR psr_o[3], whatever value the stored S bit holds.
- R5: When bst_en_i is high, T is loaded with bst_data_i[bit_sel_i] on the next edge. This overrides the T control field.
- R6: bld_result_o equals bld_data_i with bit bit_sel_i replaced by the current T flag. It is combinational.
- R7: The single-flag write acts on psr_o[flag_idx_i] on the next edge and overrides both the control fields and the bit store.
  - bset_en_i high sets the flag.
  - bclr_en_i high clears the flag.
  - When both are high, set wins.
- R8: A value written to S by the single-flag write is held through keep cycles. It is replaced by N XOR V at the next cycle whose S field is 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flag_ctl_i | input | 16 | Per-flag action, 2 bits per flag |
| alu_flags_i | input | 8 | ALU result flags in register bit order |
| bst_en_i | input | 1 | Bit store into transfer flag |
| bst_data_i | input | 8 | Operand for bit store |
| bld_data_i | input | 8 | Operand for bit load |
| bit_sel_i | input | 3 | Operand bit index for store and load |
| bset_en_i | input | 1 | Single-flag set strobe |
| bclr_en_i | input | 1 | Single-flag clear strobe |
| flag_idx_i | input | 3 | Single-flag index |
| psr_o | output | 8 | Status register |
| sign_o | output | 1 | Signed-test flag, N XOR V |
| bld_result_o | output | 8 | Operand with transfer flag inserted |

## Verification
The sign path is the main target.

- **Sign recompute.** The bench loads S while sending alu_flags_i[4] opposite to N XOR V. A design that copied the ALU bit would store the wrong sign.
- **Stale N and V.** The bench also changes N or V in the same cycle as the S load. A design that used the old N and V would lag one operation behind.
- **Forced S.** After S is forced by the single-flag port, the bench checks that sign_o still follows N XOR V and that the next S load repairs the stored bit.

Priority is covered by colliding strobes:

- set against clear;
- single-flag clear against a control-field set;
- single-flag clear against a bit store on T.

A wrong priority order would leave the losing value in the register.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned IDX_W  = $clog2(FLAG_W);
  localparam int unsigned CTL_W  = 2 * FLAG_W;

  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_Z = 1;
  localparam int unsigned FLAG_N = 2;
  localparam int unsigned FLAG_V = 3;
  localparam int unsigned FLAG_S = 4;
  localparam int unsigned FLAG_H = 5;
  localparam int unsigned FLAG_T = 6;
  localparam int unsigned FLAG_I = 7;

  typedef enum logic [1:0] {
    FCTL_KEEP = 2'b00,
    FCTL_LOAD = 2'b01,
    FCTL_CLR  = 2'b10,
    FCTL_SET  = 2'b11
  } fctl_e;

  function automatic logic flag_next(fctl_e ctl, logic cur, logic src);
    unique case (ctl)
      FCTL_KEEP: flag_next = cur;
      FCTL_LOAD: flag_next = src;
      FCTL_CLR:  flag_next = 1'b0;
      default:   flag_next = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/psr_lane.sv
module psr_lane
  import psr_pkg::*;
(
  input  fctl_e ctl_i,
  input  logic  cur_i,
  input  logic  src_i,
  output logic  nxt_o
);
  always_comb nxt_o = flag_next(ctl_i, cur_i, src_i);
endmodule

// File: rtl/psr_bit_xfer.sv
module psr_bit_xfer #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SEL_W = $clog2(DATA_W)
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] bst_data_i,
  input  logic [DATA_W-1:0] bld_data_i,
  input  logic              t_cur_i,
  output logic              t_store_o,
  output logic [DATA_W-1:0] bld_result_o
);
  always_comb t_store_o = bst_data_i[sel_i];

  for (genvar b = 0; b < DATA_W; b++) begin : g_ins
    assign bld_result_o[b] = (sel_i == SEL_W'(b)) ? t_cur_i : bld_data_i[b];
  end
endmodule

// File: rtl/psr_single_wr.sv
module psr_single_wr
  import psr_pkg::*;
(
  input  logic [FLAG_W-1:0] base_i,
  input  logic              set_en_i,
  input  logic              clr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [FLAG_W-1:0] out_o
);
  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    logic hit;
    assign hit = (idx_i == IDX_W'(b));
    // set has priority over clear
    assign out_o[b] = (hit && set_en_i) ? 1'b1 :
                      (hit && clr_en_i) ? 1'b0 : base_i[b];
  end
endmodule

// File: rtl/psr_flags.sv
module psr_flags
  import psr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SEL_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTL_W-1:0]  flag_ctl_i,
  input  logic [FLAG_W-1:0] alu_flags_i,
  input  logic              bst_en_i,
  input  logic [DATA_W-1:0] bst_data_i,
  input  logic [DATA_W-1:0] bld_data_i,
  input  logic [SEL_W-1:0]  bit_sel_i,
  input  logic              bset_en_i,
  input  logic              bclr_en_i,
  input  logic [IDX_W-1:0]  flag_idx_i,
  output logic [FLAG_W-1:0] psr_o,
  output logic              sign_o,
  output logic [DATA_W-1:0] bld_result_o
);
  logic [FLAG_W-1:0] psr_q, lane_src, lane_nxt, xfer_nxt, psr_d;
  logic              t_store, s_src, n_nxt, v_nxt;

  // sign source uses this cycle's N and V results, not the stored ones
  always_comb begin
    n_nxt = flag_next(fctl_e'(flag_ctl_i[2*FLAG_N +: 2]), psr_q[FLAG_N], alu_flags_i[FLAG_N]);
    v_nxt = flag_next(fctl_e'(flag_ctl_i[2*FLAG_V +: 2]), psr_q[FLAG_V], alu_flags_i[FLAG_V]);
    s_src = n_nxt ^ v_nxt;
  end

  for (genvar b = 0; b < FLAG_W; b++) begin : g_lane
    if (b == FLAG_S) begin : g_sign
      assign lane_src[b] = s_src;
    end else begin : g_alu
      assign lane_src[b] = alu_flags_i[b];
    end
    psr_lane u_lane (
      .ctl_i (fctl_e'(flag_ctl_i[2*b +: 2])),
      .cur_i (psr_q[b]),
      .src_i (lane_src[b]),
      .nxt_o (lane_nxt[b])
    );
  end

  psr_bit_xfer #(.DATA_W(DATA_W)) u_xfer (
    .sel_i        (bit_sel_i),
    .bst_data_i   (bst_data_i),
    .bld_data_i   (bld_data_i),
    .t_cur_i      (psr_q[FLAG_T]),
    .t_store_o    (t_store),
    .bld_result_o (bld_result_o)
  );

  always_comb begin
    xfer_nxt = lane_nxt;
    if (bst_en_i) xfer_nxt[FLAG_T] = t_store;
  end

  psr_single_wr u_swr (
    .base_i   (xfer_nxt),
    .set_en_i (bset_en_i),
    .clr_en_i (bclr_en_i),
    .idx_i    (flag_idx_i),
    .out_o    (psr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psr_q <= '0;
    else         psr_q <= psr_d;
  end

  assign psr_o  = psr_q;
  assign sign_o = psr_q[FLAG_N] ^ psr_q[FLAG_V];
endmodule

// File: rtl/psr_flags_chk.sv
module psr_flags_chk
  import psr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SEL_W = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CTL_W-1:0]  flag_ctl_i,
  input logic [FLAG_W-1:0] alu_flags_i,
  input logic              bst_en_i,
  input logic [DATA_W-1:0] bst_data_i,
  input logic [DATA_W-1:0] bld_data_i,
  input logic [SEL_W-1:0]  bit_sel_i,
  input logic              bset_en_i,
  input logic              bclr_en_i,
  input logic [IDX_W-1:0]  flag_idx_i,
  input logic [FLAG_W-1:0] psr_o,
  input logic              sign_o,
  input logic [DATA_W-1:0] bld_result_o
);
  logic any_swr;
  assign any_swr = bset_en_i || bclr_en_i;

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_ctl_i == '0 && !bst_en_i && !any_swr) |=> $stable(psr_o));

  assert_clear_c_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_ctl_i[2*FLAG_C +: 2] == 2'b10 && !(bset_en_i && flag_idx_i == IDX_W'(FLAG_C)))
    |=> !psr_o[FLAG_C]);

  assert_sign_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_ctl_i[2*FLAG_S +: 2] == 2'b01 && !any_swr) |=> psr_o[FLAG_S] == sign_o);

  assert_bit_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bst_en_i && !(any_swr && flag_idx_i == IDX_W'(FLAG_T)))
    |=> psr_o[FLAG_T] == $past(bst_data_i[bit_sel_i]));

  assert_single_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bset_en_i |=> psr_o[$past(flag_idx_i)]);

  assert_single_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bclr_en_i && !bset_en_i) |=> !psr_o[$past(flag_idx_i)]);

  always_comb begin
    if (rst_ni) begin
      assert_bld_insert_R6: assert (bld_result_o[bit_sel_i] == psr_o[FLAG_T]);
    end
  end
endmodule

bind psr_flags psr_flags_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/psr_flags_test.sv
`timescale 1ns/1ps
module psr_flags_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] flag_ctl;
  logic [7:0]  alu_flags, bst_data, bld_data, psr, bld_result;
  logic [2:0]  bit_sel, flag_idx;
  logic        bst_en, bset_en, bclr_en, sign;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  psr_flags uut (
    .clk_i(clk), .rst_ni(rst_ni), .flag_ctl_i(flag_ctl), .alu_flags_i(alu_flags),
    .bst_en_i(bst_en), .bst_data_i(bst_data), .bld_data_i(bld_data),
    .bit_sel_i(bit_sel), .bset_en_i(bset_en), .bclr_en_i(bclr_en),
    .flag_idx_i(flag_idx), .psr_o(psr), .sign_o(sign), .bld_result_o(bld_result)
  );

  // {ctl, alu, expected psr}, applied in order from reset
  localparam logic [31:0] VEC [9] = '{
    {16'h5555, 8'hFF, 8'hEF},  // all load, S = N^V = 0
    {16'hAAAA, 8'hFF, 8'h00},  // all clear
    {16'hFFFF, 8'h00, 8'hFF},  // all set
    {16'h0000, 8'h00, 8'hFF},  // all keep
    {16'h0150, 8'h04, 8'hF7},  // N,V,S load: N1 V0 -> S1
    {16'h0150, 8'h0C, 8'hEF},  // N1 V1 -> S0
    {16'h0C06, 8'h02, 8'hEE},  // C clr, Z load, H set
    {16'h8000, 8'hFF, 8'h6E},  // I clear
    {16'h0100, 8'h10, 8'h6E}   // S load ignores alu bit 4
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    flag_ctl = '0; alu_flags = '0; bst_en = 0; bst_data = '0; bld_data = '0;
    bit_sel = '0; bset_en = 0; bclr_en = 0; flag_idx = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic swr(bit set, bit clr, logic [2:0] idx);
    bset_en = set; bclr_en = clr; flag_idx = idx;
    tick(); idle();
  endtask

  initial begin
    idle();
    #1;
    chk("R1 reset psr", psr, 8'h00);
    chk("R1 reset sign", {7'd0, sign}, 8'h00);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 after release", psr, 8'h00);

    for (int i = 0; i < 9; i++) begin
      flag_ctl = VEC[i][31:16]; alu_flags = VEC[i][15:8];
      tick();
      chk($sformatf("R2/R3 vector %0d", i), psr, VEC[i][7:0]);
      chk($sformatf("R4 vector %0d", i), {7'd0, sign}, {7'd0, VEC[i][2] ^ VEC[i][3]});
      idle();
    end

    // R5: bit store overrides T control field set
    bst_en = 1; bst_data = 8'hFE; bit_sel = 3'd0; flag_ctl = 16'h3000;
    tick(); idle();
    chk("R5 store T=0", psr, 8'h2E);

    // R6: bit load inserts T
    bld_data = 8'hFF; bit_sel = 3'd5; #1;
    chk("R6 load T=0", bld_result, 8'hDF);
    idle();
    bst_en = 1; bst_data = 8'h80; bit_sel = 3'd7;
    tick(); idle();
    chk("R5 store T=1", psr, 8'h6E);
    bld_data = 8'h00; bit_sel = 3'd3; #1;
    chk("R6 load T=1", bld_result, 8'h08);
    idle();

    // R7: single-flag write
    swr(1, 0, 3'd7); chk("R7 set I", psr, 8'hEE);
    swr(0, 1, 3'd1); chk("R7 clear Z", psr, 8'hEC);
    swr(1, 1, 3'd0); chk("R7 set wins", psr, 8'hED);
    flag_ctl = 16'h0030; swr(0, 1, 3'd2);
    chk("R7 clear over ctl set", psr, 8'hE9);
    bst_en = 1; bst_data = 8'hFF; bit_sel = 3'd0; swr(0, 1, 3'd6);
    chk("R7 clear over bit store", psr, 8'hA9);

    // R8: forced S held until next S load
    swr(1, 0, 3'd2); chk("R8 set N", psr, 8'hAD);
    swr(1, 0, 3'd4); chk("R8 force S", psr, 8'hBD);
    chk("R4 sign ignores stored S", {7'd0, sign}, 8'h00);
    tick(); chk("R8 S held", psr, 8'hBD);
    flag_ctl = 16'h0100; tick(); idle();
    chk("R8 S recomputed", psr, 8'hAD);

    // R1: asynchronous reset mid-run
    #1 rst_ni = 1'b0; #1;
    chk("R1 async reset", psr, 8'h00);
    @(negedge clk); rst_ni = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule